// File: doc/BRIEF.md
# Dual-Thread Vector Issue Arbiter

This block lets two independent instruction threads share a pair of element-wise multiply-accumulate lanes. Each thread holds its own private bank of vector registers and offers vector operations through a valid/ready handshake. Each operation has an opcode, two source register indices and a destination index. On every clock the arbiter looks only at which threads are asking for vector work. If both ask, each thread gets a lane of its own. If only one asks, that thread's operation is split over both lanes and takes half the cycles.

A vector holds `VLEN` elements of `EW` bits. Each lane processes `LANE_W` elements per cycle, so the unit performs `2*LANE_W` multiply-accumulates per cycle. That figure reaches 128 with `LANE_W = 64`. An operation on one lane takes `BEATS = VLEN/LANE_W` cycles. A split operation takes `BEATS/2` cycles. Lane 0 covers the lower half of the elements and lane 1 the upper half. Element e lives at bits `[e*EW +: EW]` of a register. Each thread also has a load port and a read port on its own register file. Through these ports the surrounding core fills registers and reads results.

Top module: `vdt_core`

## Requirements
- R1: After reset both ready outputs are 1 and both lanes are idle (`lane_busy_o = 2'b00`, `lane_thr_o = 2'b00`). Every register of both threads reads as zero.
- R2: When both threads are accepted on the same edge, from the next cycle lane 0 serves thread 0 and lane 1 serves thread 1 (`lane_thr_o = 2'b10`, `lane_busy_o = 2'b11`), and both operations take `BEATS` cycles.
- R3: When exactly one thread is accepted, both lanes serve that thread from the next cycle (`lane_thr_o` holds the thread number in both bits), and the operation takes `BEATS/2` cycles.
- R4: A split operation gives elements `0 .. VLEN/2-1` to lane 0 and the rest to lane 1. The result lands in the owning thread's destination register in the original element order.
- R5: Opcode encodings, applied per element modulo 2^EW with c the old destination element: 0 gives a*b, 1 gives c+a*b, 2 gives a+b, 3 gives a-b.
- R6: An operation never reads or changes the registers of the other thread.
- R7: Ready is 1 while the lanes are idle or in the final beat of the running operation, and 0 otherwise. A running operation finishes on the lanes it was given. A thread that starts asking meanwhile waits for the next free cycle.
- R8: With both threads asking on every cycle, each thread is accepted once every `BEATS` cycles. A thread asking alone on every cycle is accepted once every `BEATS/2` cycles.
- R9: A load writes a whole register, and the new value is visible on the read port from the next cycle. The read port returns the addressed register with no clock delay.
- R10: The destination may equal a source. Each element is computed from the values held before the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 2 | Operation request, one bit per thread |
| req_ready_o | output | 2 | Request accepted on this edge if valid, one bit per thread |
| req_op_i | input | 4 | Opcode per thread, 2 bits each |
| req_src_a_i | input | 2*RW | First source register index per thread |
| req_src_b_i | input | 2*RW | Second source register index per thread |
| req_dst_i | input | 2*RW | Destination register index per thread |
| ld_en_i | input | 2 | Register load strobe per thread |
| ld_idx_i | input | 2*RW | Load register index per thread |
| ld_data_i | input | 2*VLEN*EW | Load data per thread |
| rd_idx_i | input | 2*RW | Read port register index per thread |
| rd_data_o | output | 2*VLEN*EW | Read port data per thread |
| lane_busy_o | output | 2 | Lane is executing in this cycle |
| lane_thr_o | output | 2 | Thread served by each lane |

## Verification
An operation accepted on an edge shows up in the lane status outputs one cycle later. Its full result can be read `BEATS` cycles after that edge when it runs on one lane, and `BEATS/2` cycles after it when split. Ready returns during the last of those cycles. The bench keeps a behavioural model of the lane occupancy and of both register banks. It compares ready and lane status at every falling edge. It reads the registers back only once the model has gone idle, so that every write has landed. Acceptance cycles are recorded so that issue spacing and the split speed-up can be compared against the same whole-cycle counts.

// File: rtl/vdt_pkg.sv
package vdt_pkg;
  typedef enum logic [1:0] {
    VOP_MUL = 2'd0,
    VOP_MAC = 2'd1,
    VOP_ADD = 2'd2,
    VOP_SUB = 2'd3
  } vop_e;
endpackage

// File: rtl/vdt_lane.sv
module vdt_lane
  import vdt_pkg::*;
#(
  parameter int EW     = 16,
  parameter int LANE_W = 4
) (
  input  vop_e                   op_i,
  input  logic [LANE_W*EW-1:0]   a_i,
  input  logic [LANE_W*EW-1:0]   b_i,
  input  logic [LANE_W*EW-1:0]   c_i,
  output logic [LANE_W*EW-1:0]   res_o
);
  for (genvar e = 0; e < LANE_W; e++) begin : g_el
    logic [EW-1:0] a, b, c, r;
    assign a = a_i[e*EW +: EW];
    assign b = b_i[e*EW +: EW];
    assign c = c_i[e*EW +: EW];
    always_comb begin
      unique case (op_i)
        VOP_MUL: r = a * b;
        VOP_MAC: r = c + a * b;
        VOP_ADD: r = a + b;
        VOP_SUB: r = a - b;
      endcase
    end
    assign res_o[e*EW +: EW] = r;
  end
endmodule

// File: rtl/vdt_vrf.sv
module vdt_vrf #(
  parameter int NREG = 4,
  parameter int VW   = 256,
  parameter int RW   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [RW-1:0] ld_idx_i,
  input  logic [VW-1:0] ld_data_i,
  input  logic [RW-1:0] wr_idx_i,
  input  logic [VW-1:0] wr_mask_i,
  input  logic [VW-1:0] wr_data_i,
  input  logic [RW-1:0] ra_idx_i,
  input  logic [RW-1:0] rb_idx_i,
  input  logic [RW-1:0] rc_idx_i,
  input  logic [RW-1:0] rp_idx_i,
  output logic [VW-1:0] ra_o,
  output logic [VW-1:0] rb_o,
  output logic [VW-1:0] rc_o,
  output logic [VW-1:0] rp_o
);
  logic [VW-1:0] mem_q [NREG];
  logic [VW-1:0] mem_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      mem_d[r] = mem_q[r];
      if (ld_en_i && ld_idx_i == RW'(r)) mem_d[r] = ld_data_i;
      // lane writes land on top of a same-cycle load
      if (wr_idx_i == RW'(r)) mem_d[r] = (mem_d[r] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= mem_d[r];
    end
  end

  assign ra_o = mem_q[ra_idx_i];
  assign rb_o = mem_q[rb_idx_i];
  assign rc_o = mem_q[rc_idx_i];
  assign rp_o = mem_q[rp_idx_i];
endmodule

// File: rtl/vdt_issue.sv
module vdt_issue #(
  parameter int   BEATS = 4,
  localparam int  BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    valid_i,
  output logic [1:0]    ready_o,
  output logic [1:0]    start_o,
  output logic          busy_o,
  output logic          striped_o,
  output logic          owner_o,
  output logic [BW-1:0] beat_o
);
  logic          busy_q, striped_q, owner_q;
  logic [BW-1:0] beat_q, last;
  logic          free;

  assign last    = striped_q ? BW'(BEATS/2 - 1) : BW'(BEATS - 1);
  assign free    = !busy_q || (beat_q == last);
  assign ready_o = {free, free};
  assign start_o = valid_i & {free, free};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      striped_q <= 1'b0;
      owner_q   <= 1'b0;
      beat_q    <= '0;
    end else if (free) begin
      beat_q <= '0;
      if (|valid_i) begin
        busy_q    <= 1'b1;
        striped_q <= (valid_i != 2'b11);
        owner_q   <= (valid_i == 2'b10);
      end else begin
        busy_q <= 1'b0;
      end
    end else begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign striped_o = striped_q;
  assign owner_o   = owner_q;
  assign beat_o    = beat_q;
endmodule

// File: rtl/vdt_core.sv
module vdt_core
  import vdt_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int VLEN   = 16,
  parameter int EW     = 16,
  parameter int LANE_W = 4,
  localparam int RW    = $clog2(NREG),
  localparam int VW    = VLEN * EW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      req_valid_i,
  output logic [1:0]      req_ready_o,
  input  logic [3:0]      req_op_i,
  input  logic [2*RW-1:0] req_src_a_i,
  input  logic [2*RW-1:0] req_src_b_i,
  input  logic [2*RW-1:0] req_dst_i,
  input  logic [1:0]      ld_en_i,
  input  logic [2*RW-1:0] ld_idx_i,
  input  logic [2*VW-1:0] ld_data_i,
  input  logic [2*RW-1:0] rd_idx_i,
  output logic [2*VW-1:0] rd_data_o,
  output logic [1:0]      lane_busy_o,
  output logic [1:0]      lane_thr_o
);
  localparam int LW    = LANE_W * EW;
  localparam int BEATS = VLEN / LANE_W;
  localparam int HALFE = VLEN / 2;
  localparam int OW    = $clog2(VW);
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [1:0]    start;
  logic          busy, striped, owner;
  logic [BW-1:0] beat;

  vdt_issue #(.BEATS(BEATS)) u_issue (
    .clk_i, .rst_ni,
    .valid_i  (req_valid_i),
    .ready_o  (req_ready_o),
    .start_o  (start),
    .busy_o   (busy),
    .striped_o(striped),
    .owner_o  (owner),
    .beat_o   (beat)
  );

  // per-thread operation held for the whole run
  vop_e          op_q [2];
  logic [RW-1:0] sa_q [2];
  logic [RW-1:0] sb_q [2];
  logic [RW-1:0] sd_q [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < 2; t++) begin
        op_q[t] <= VOP_MUL;
        sa_q[t] <= '0;
        sb_q[t] <= '0;
        sd_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (start[t]) begin
          op_q[t] <= vop_e'(req_op_i[t*2 +: 2]);
          sa_q[t] <= req_src_a_i[t*RW +: RW];
          sb_q[t] <= req_src_b_i[t*RW +: RW];
          sd_q[t] <= req_dst_i[t*RW +: RW];
        end
      end
    end
  end

  logic [VW-1:0] rf_a [2];
  logic [VW-1:0] rf_b [2];
  logic [VW-1:0] rf_c [2];
  logic [VW-1:0] wmask [2];
  logic [VW-1:0] wdata [2];
  logic [1:0]    lthr;
  logic [OW-1:0] off [2];
  logic [LW-1:0] lres [2];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lthr[l] = striped ? owner : 1'(l);
    // split run: lane l covers element half l
    always_comb off[l] = OW'((int'(beat) * LANE_W + (striped ? l * HALFE : 0)) * EW);

    vdt_lane #(.EW(EW), .LANE_W(LANE_W)) u_lane (
      .op_i (op_q[lthr[l]]),
      .a_i  (rf_a[lthr[l]][off[l] +: LW]),
      .b_i  (rf_b[lthr[l]][off[l] +: LW]),
      .c_i  (rf_c[lthr[l]][off[l] +: LW]),
      .res_o(lres[l])
    );
  end

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      wmask[t] = '0;
      wdata[t] = '0;
      for (int l = 0; l < 2; l++) begin
        if (busy && lthr[l] == 1'(t)) begin
          wmask[t][off[l] +: LW] = '1;
          wdata[t][off[l] +: LW] = lres[l];
        end
      end
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_thr
    vdt_vrf #(.NREG(NREG), .VW(VW), .RW(RW)) u_vrf (
      .clk_i, .rst_ni,
      .ld_en_i  (ld_en_i[t]),
      .ld_idx_i (ld_idx_i[t*RW +: RW]),
      .ld_data_i(ld_data_i[t*VW +: VW]),
      .wr_idx_i (sd_q[t]),
      .wr_mask_i(wmask[t]),
      .wr_data_i(wdata[t]),
      .ra_idx_i (sa_q[t]),
      .rb_idx_i (sb_q[t]),
      .rc_idx_i (sd_q[t]),
      .rp_idx_i (rd_idx_i[t*RW +: RW]),
      .ra_o     (rf_a[t]),
      .rb_o     (rf_b[t]),
      .rc_o     (rf_c[t]),
      .rp_o     (rd_data_o[t*VW +: VW])
    );
  end

  assign lane_busy_o = {busy, busy};
  assign lane_thr_o  = busy ? lthr : 2'b00;
endmodule

// File: rtl/vdt_chk.sv
module vdt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] req_valid_i,
  input logic [1:0] req_ready_o,
  input logic [1:0] lane_busy_o,
  input logic [1:0] lane_thr_o
);
  // R2
  paired_steer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i & req_ready_o) == 2'b11 |=> lane_busy_o == 2'b11 && lane_thr_o == 2'b10);

  // R3
  solo_steer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(req_valid_i & req_ready_o) == 1
      |=> lane_busy_o == 2'b11 && lane_thr_o == {2{$past(req_valid_i[1])}});

  // R7
  stall_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == 2'b00 |-> lane_busy_o == 2'b11);

  // R7
  hold_steer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == 2'b00 |=> lane_busy_o == 2'b11 && $stable(lane_thr_o));

  // R7
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_busy_o == 2'b00 |-> req_ready_o == 2'b11);
endmodule

bind vdt_core vdt_chk u_vdt_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .lane_busy_o(lane_busy_o),
  .lane_thr_o (lane_thr_o)
);

// File: tb/tb_vdt_core.sv
module tb_vdt_core;
  localparam int NREG = 4, VLEN = 16, EW = 16, LANE_W = 4;
  localparam int RW = 2, VW = VLEN * EW;
  localparam int B = VLEN / LANE_W, HB = B / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]      req_valid = '0, req_ready;
  logic [3:0]      req_op = '0;
  logic [2*RW-1:0] req_sa = '0, req_sb = '0, req_sd = '0;
  logic [1:0]      ld_en = '0;
  logic [2*RW-1:0] ld_idx = '0, rd_idx = '0;
  logic [2*VW-1:0] ld_data = '0, rd_data;
  logic [1:0]      lane_busy, lane_thr;

  vdt_core #(.NREG(NREG), .VLEN(VLEN), .EW(EW), .LANE_W(LANE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_src_a_i(req_sa), .req_src_b_i(req_sb), .req_dst_i(req_sd),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .lane_busy_o(lane_busy), .lane_thr_o(lane_thr)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference state
  logic [EW-1:0] ref_rf [2][NREG][VLEN];
  bit m_busy = 0, m_str = 0, m_own = 0;
  int m_rem = 0;

  typedef struct { int op; int sa; int sb; int sd; int at; } vop_t;
  vop_t q0[$], q1[$];
  int acc_c [2][8];
  int acc_n [2];

  function automatic logic [EW-1:0] ref_el(int op, logic [EW-1:0] a, logic [EW-1:0] b, logic [EW-1:0] c);
    case (op)
      0: return a * b;
      1: return c + a * b;
      2: return a + b;
      default: return a - b;
    endcase
  endfunction

  function automatic logic [VW-1:0] ref_vec(int t, int r);
    logic [VW-1:0] v;
    for (int e = 0; e < VLEN; e++) v[e*EW +: EW] = ref_rf[t][r][e];
    return v;
  endfunction

  task automatic apply(int t, vop_t o);
    for (int e = 0; e < VLEN; e++)
      ref_rf[t][o.sd][e] = ref_el(o.op, ref_rf[t][o.sa][e], ref_rf[t][o.sb][e], ref_rf[t][o.sd][e]);
  endtask

  task automatic push(int t, int op, int sa, int sb, int sd, int at);
    vop_t o;
    o.op = op; o.sa = sa; o.sb = sb; o.sd = sd; o.at = at;
    if (t == 0) q0.push_back(o); else q1.push_back(o);
  endtask

  task automatic chk_regs(input string req);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      rd_idx = {RW'(r), RW'(r)};
      #1;
      for (int t = 0; t < 2; t++)
        chk(rd_data[t*VW +: VW] == ref_vec(t, r), req, $sformatf("thread %0d reg %0d", t, r),
            rd_data[t*VW +: VW], ref_vec(t, r));
    end
  endtask

  task automatic load_all();
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      ld_en = 2'b11;
      ld_idx = {RW'(r), RW'(r)};
      for (int t = 0; t < 2; t++)
        for (int e = 0; e < VLEN; e++) begin
          ref_rf[t][r][e] = EW'($urandom);
          ld_data[t*VW + e*EW +: EW] = ref_rf[t][r][e];
        end
    end
    @(negedge clk);
    ld_en = 2'b00;
  endtask

  // cycle-by-cycle run of the queued operations
  task automatic run_sched();
    int cyc = 0;
    logic [1:0] v, acc, exp_lt;
    bit exp_rdy;
    acc_n[0] = 0; acc_n[1] = 0;
    while (q0.size() > 0 || q1.size() > 0 || m_busy) begin
      @(negedge clk);
      exp_rdy = !m_busy || m_rem == 1;
      exp_lt  = !m_busy ? 2'b00 : (m_str ? {m_own, m_own} : 2'b10);
      chk(req_ready == {exp_rdy, exp_rdy}, "R7", "ready", VW'(req_ready), VW'({exp_rdy, exp_rdy}));
      chk(lane_busy == {m_busy, m_busy}, "R2/R3", "lane busy", VW'(lane_busy), VW'({m_busy, m_busy}));
      chk(lane_thr == exp_lt, "R2/R3", "lane steering", VW'(lane_thr), VW'(exp_lt));
      v[0] = q0.size() > 0 && cyc >= q0[0].at;
      v[1] = q1.size() > 0 && cyc >= q1[0].at;
      req_valid = v;
      if (v[0]) begin
        req_op[1:0] = 2'(q0[0].op); req_sa[RW-1:0] = RW'(q0[0].sa);
        req_sb[RW-1:0] = RW'(q0[0].sb); req_sd[RW-1:0] = RW'(q0[0].sd);
      end
      if (v[1]) begin
        req_op[3:2] = 2'(q1[0].op); req_sa[2*RW-1:RW] = RW'(q1[0].sa);
        req_sb[2*RW-1:RW] = RW'(q1[0].sb); req_sd[2*RW-1:RW] = RW'(q1[0].sd);
      end
      acc = exp_rdy ? v : 2'b00;
      if (acc[0]) begin apply(0, q0[0]); acc_c[0][acc_n[0]] = cyc; acc_n[0]++; void'(q0.pop_front()); end
      if (acc[1]) begin apply(1, q1[0]); acc_c[1][acc_n[1]] = cyc; acc_n[1]++; void'(q1.pop_front()); end
      if (exp_rdy) begin
        if (|acc) begin
          m_busy = 1; m_str = (acc != 2'b11); m_own = (acc == 2'b10);
          m_rem = m_str ? HB : B;
        end else m_busy = 0;
      end else m_rem--;
      cyc++;
    end
    @(negedge clk);
    req_valid = 2'b00;
  endtask

  int span_pair, span_solo;

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < VLEN; e++) ref_rf[t][r][e] = '0;
    repeat (3) @(negedge clk);
    chk(lane_busy == 2'b00 && lane_thr == 2'b00, "R1", "lanes in reset", VW'({lane_busy, lane_thr}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 2'b11, "R1", "ready after reset", VW'(req_ready), VW'(2'b11));
    chk_regs("R1");

    load_all();
    chk_regs("R9");

    // R3 R4 R5 R6: each opcode split over both lanes, one thread at a time
    for (int k = 0; k < 4; k++) begin
      push(0, k, k, (k + 1) % NREG, (k + 2) % NREG, 0);
      push(1, 3 - k, (k + 3) % NREG, k, (k + 1) % NREG, 12);
      run_sched();
      chk_regs("R5");
    end

    // R2: paired ops, one lane each
    push(0, 1, 0, 1, 2, 0);
    push(1, 3, 2, 3, 0, 0);
    run_sched();
    chk(acc_c[0][0] == acc_c[1][0], "R2", "paired accept cycle", VW'(acc_c[1][0]), VW'(acc_c[0][0]));
    chk_regs("R6");

    // R7: thread 1 arrives during thread 0's split run and waits
    push(0, 2, 1, 2, 3, 0);
    push(1, 1, 0, 3, 1, 1);
    run_sched();
    chk(acc_c[1][0] - acc_c[0][0] == HB, "R7", "late thread waits", VW'(acc_c[1][0] - acc_c[0][0]), VW'(HB));
    chk_regs("R4");

    // R8: peak load, both threads every cycle
    for (int k = 0; k < 4; k++) begin push(0, k, k, 3 - k, k, 0); push(1, 3 - k, 3 - k, k, 2, 0); end
    run_sched();
    for (int k = 0; k < 3; k++)
      for (int t = 0; t < 2; t++)
        chk(acc_c[t][k+1] - acc_c[t][k] == B, "R8", $sformatf("peak spacing t%0d", t),
            VW'(acc_c[t][k+1] - acc_c[t][k]), VW'(B));
    span_pair = acc_c[0][3] - acc_c[0][0] + B;
    chk_regs("R8");

    // R8: same thread alone
    for (int k = 0; k < 4; k++) push(0, k, k, 3 - k, k, 0);
    run_sched();
    for (int k = 0; k < 3; k++)
      chk(acc_c[0][k+1] - acc_c[0][k] == HB, "R8", "solo spacing",
          VW'(acc_c[0][k+1] - acc_c[0][k]), VW'(HB));
    span_solo = acc_c[0][3] - acc_c[0][0] + HB;
    chk(2 * span_solo == span_pair, "R8", "solo half of contended", VW'(2 * span_solo), VW'(span_pair));
    chk_regs("R3");

    // R10: destination equals both sources
    push(1, 0, 2, 2, 2, 0);
    push(0, 1, 3, 3, 3, 0);
    run_sched();
    push(1, 1, 1, 1, 1, 0);
    run_sched();
    chk_regs("R10");

    // R9: reload then read back immediately
    load_all();
    chk_regs("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule